// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each data beat of a synchronous DRAM read or write burst. A controller loads the burst length and the wrap ordering into a small mode register. It then pulses `start` with the first column of the access. The sequencer drives that column straight away and moves to the next one on every cycle in which `advance` is high. The controller steps the sequencer in lockstep with its data transfers and uses `last` to know when a fixed-length burst is complete.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of columns that contains the starting column. The beats follow either an incrementing order that wraps, or an interleaved order in which the low address bits are flipped by a beat count. Full-page bursts step through the whole 512-column row and wrap around. They never signal a last beat and end only when `terminate` is raised. A start pulse that arrives during a burst abandons the current burst and begins a new one.

Top module: `burst_col_seq`

## Requirements
- R1: A high `mode_load` at a clock edge stores `mode_bl` and `mode_ilv` into the mode register. A burst uses the mode held when its start pulse is taken, so loading a new mode during a burst leaves that burst unchanged, and the next burst uses the new mode.
- R2: When `start` is high at a clock edge, from the next cycle `busy` is 1 and `col` equals the `start_col` that was sampled. This holds whether the block was idle or already in a burst.
- R3: Burst length code `mode_bl`: 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, 7 = full page. With `mode_ilv` = 0 and a fixed length BL, each advance adds 1 to the low log2(BL) column bits modulo BL, and the upper column bits stay at their starting value.
- R4: With `mode_ilv` = 1 and a fixed length BL, the low log2(BL) bits of beat k equal the starting low bits XOR k, and the upper bits stay fixed.
- R5: `last` is 1 exactly while the BL-th column of a fixed burst is shown. An advance taken while `last` is 1 ends the burst, so `busy` is 0 from the next cycle.
- R6: In full-page mode (code 7) each advance adds 1 to the column modulo 512, for either ordering, and `last` stays 0 for the whole burst.
- R7: `terminate` high at an edge during a burst ends it, so `busy` is 0 from the next cycle, and `col` keeps the column that was shown. `start` takes priority over `terminate` and over `advance` at the same edge.
- R8: While the block is idle, `advance` and `terminate` have no effect: `busy` stays 0 and `col` holds its value.
- R9: After reset, `busy` = 0, `last` = 0, `col` = 0, and the mode register holds length code 0 with sequential ordering.
- R10: A one-beat burst shows `last` = 1 on its only column. The reserved length codes 4, 5 and 6 give one-beat bursts.
- R11: A cycle of a burst in which `advance` is low, with no `start` or `terminate`, leaves `col`, `last` and `busy` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_load | input | 1 | Write strobe for the mode register |
| mode_bl | input | 3 | Burst length code to store |
| mode_ilv | input | 1 | Ordering to store: 1 interleaved, 0 sequential |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 9 | First column of the burst |
| advance | input | 1 | Step to the next column of the burst |
| terminate | input | 1 | End the current burst |
| col | output | 9 | Column for the current beat |
| last | output | 1 | Current beat is the final one of a fixed burst |
| busy | output | 1 | A burst is in progress |

## Verification
The bench starts bursts at unaligned columns so that the wrap point sits in the middle of the block. A design that carried into the upper bits, or that wrapped sequential bursts the way interleaved ones wrap, would produce columns outside the aligned block or in the wrong order. Full-page bursts are started just below column 512 with interleave selected. This catches a design that fails to wrap the page, flips bits in full-page mode, or raises `last`. The bench also restarts a burst while it is running with terminate raised at the same edge, loads a new mode in the middle of a burst, stalls bursts with `advance` low, and toggles `advance` and `terminate` while idle. These cases expose designs that drop the restart, let the new mode change the running burst, move during stalls, or wake up without a start pulse.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam int BL_CODE_W = 3;
    localparam logic [BL_CODE_W-1:0] BL_CODE_FULL = 3'd7;

    typedef struct packed {
        logic [BL_CODE_W-1:0] bl_code;
        logic                 ilv;
    } burst_mode_t;

    localparam burst_mode_t MODE_RESET = '{bl_code: '0, ilv: 1'b0};

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_col_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [BL_CODE_W-1:0] bl_in,
    input  logic                 ilv_in,
    output burst_mode_t          mode
);

    burst_mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (load) begin
            mode_d.bl_code = bl_in;
            mode_d.ilv     = ilv_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 3
) (
    input  burst_mode_t      mode,
    output logic [COL_W-1:0] wrap_mask,
    output logic             full_page,
    output logic             ilv_eff
);

    localparam int CODE_MAX = MAX_LOG;

    logic                 fixed_ok;
    logic [BL_CODE_W-1:0] log_eff;

    always_comb begin
        full_page = (mode.bl_code == BL_CODE_FULL);
        fixed_ok  = (32'(mode.bl_code) <= CODE_MAX);
        log_eff   = fixed_ok ? mode.bl_code : '0;
        ilv_eff   = mode.ilv && !full_page;
    end

    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign wrap_mask[i] = full_page || (i < 32'(log_eff));
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] ilv_val;

    always_comb begin
        seq_sum = base_col + beat;
        ilv_val = base_col ^ beat;
    end

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!wrap_mask[i]) begin
                col[i] = base_col[i];
            end else if (ilv) begin
                col[i] = ilv_val[i];
            end else begin
                col[i] = seq_sum[i];
            end
        end
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_col_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_load,
    input  logic [BL_CODE_W-1:0] mode_bl,
    input  logic                 mode_ilv,
    input  logic                 start,
    input  logic [COL_W-1:0]     start_col,
    input  logic                 advance,
    input  logic                 terminate,
    output logic [COL_W-1:0]     col,
    output logic                 last,
    output logic                 busy
);

    typedef struct packed {
        logic             busy;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        logic             full;
        logic             ilv;
    } seq_state_t;

    burst_mode_t      mode_cur;
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_ilv;
    logic [COL_W-1:0] beat_inc;
    logic [COL_W-1:0] gen_col;
    logic             last_w;

    seq_state_t st_d, st_q;

    burst_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mode_load),
        .bl_in  (mode_bl),
        .ilv_in (mode_ilv),
        .mode   (mode_cur)
    );

    burst_len_decode #(
        .COL_W   (COL_W),
        .MAX_LOG (MAX_LOG)
    ) u_dec (
        .mode      (mode_cur),
        .wrap_mask (dec_mask),
        .full_page (dec_full),
        .ilv_eff   (dec_ilv)
    );

    assign beat_inc = st_q.beat + COL_W'(1);

    burst_col_gen #(
        .COL_W (COL_W)
    ) u_gen (
        .base_col  (st_q.base),
        .beat      (beat_inc),
        .wrap_mask (st_q.mask),
        .ilv       (st_q.ilv),
        .col       (gen_col)
    );

    // final beat of a fixed burst: the beat count has reached BL-1
    assign last_w = st_q.busy && !st_q.full && (st_q.beat == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.base = start_col;
            st_d.col  = start_col;
            st_d.beat = '0;
            st_d.mask = dec_mask;
            st_d.full = dec_full;
            st_d.ilv  = dec_ilv;
        end else if (st_q.busy && terminate) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy && advance) begin
            if (last_w) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.beat = beat_inc;
                st_d.col  = gen_col;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col  = st_q.col;
    assign busy = st_q.busy;
    assign last = last_w;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             advance,
    input logic             terminate,
    input logic [COL_W-1:0] col,
    input logic             last,
    input logic             busy
);

    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && col == $past(start_col)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> (!busy && $stable(col)));

    p_term_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && terminate && !start) |=> (!busy && $stable(col)));

    p_last_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (last && advance && !start && !terminate) |=> !busy);

    p_last_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> busy);

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !advance && !start && !terminate) |=>
            (busy && $stable(col) && $stable(last)));

    p_adv_cont_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && advance && !last && !start && !terminate) |=> busy);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .advance   (advance),
    .terminate (terminate),
    .col       (col),
    .last      (last),
    .busy      (busy)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_load = 1'b0;
    logic [2:0] mode_bl = '0;
    logic       mode_ilv = 1'b0;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic       advance = 1'b0;
    logic       terminate = 1'b0;
    logic [8:0] col;
    logic       last;
    logic       busy;

    typedef struct {
        logic [8:0] col;
        logic       last;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   n_cyc = 0;
    logic [2:0] tb_bl = '0;
    logic       tb_il = 1'b0;

    always #2 clk = ~clk;

    burst_col_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_load (mode_load),
        .mode_bl   (mode_bl),
        .mode_ilv  (mode_ilv),
        .start     (start),
        .start_col (start_col),
        .advance   (advance),
        .terminate (terminate),
        .col       (col),
        .last      (last),
        .busy      (busy)
    );

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cyc <= n_cyc + 1;
        if (n_cyc > 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected < 20000", n_cyc);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: one expected item per busy cycle
    always @(negedge clk) begin
        if (rst_n && busy === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected beat R8", int'(col), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(col === e.col, {e.tag, " col"}, int'(col), int'(e.col));
                check(last === e.last, {e.tag, " last"}, int'(last), int'(e.last));
            end
        end
    end

    function automatic int model_len(input logic [2:0] code);
        if (code <= 3'd3) return 1 << code;
        if (code == 3'd7) return 512;
        return 1;
    endfunction

    function automatic logic [8:0] model_col(input logic [8:0] sc, input int beat,
                                             input logic [2:0] code, input logic il);
        int   len;
        logic [8:0] mask;
        logic [8:0] b;
        len  = model_len(code);
        mask = 9'(len - 1);
        b    = 9'(beat);
        if (il && code != 3'd7) return (sc & ~mask) | ((sc ^ b) & mask);
        return (sc & ~mask) | ((sc + b) & mask);
    endfunction

    task automatic set_mode(input logic [2:0] code, input logic il);
        @(posedge clk); #1;
        mode_load = 1'b1; mode_bl = code; mode_ilv = il;
        @(posedge clk); #1;
        mode_load = 1'b0;
        tb_bl = code; tb_il = il;
    endtask

    task automatic start_pulse(input logic [8:0] sc);
        @(posedge clk); #1;
        start = 1'b1; start_col = sc; advance = 1'b0; terminate = 1'b0;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    // entered just after the edge that captured start; drives the rest of the burst
    task automatic run_beats(input logic [8:0] sc, input int maxc, input bit stall,
                             input bit term, input bit chg_mode, input string tag,
                             output logic [8:0] held);
        int   beat = 0;
        bit   active = 1'b1;
        int   len = model_len(tb_bl);
        bit   full = (tb_bl == 3'd7);
        logic [2:0] code = tb_bl;
        logic il = tb_il;
        for (int c = 0; active && c < 2000; c++) begin
            exp_t e;
            bit adv, tn;
            e.col  = model_col(sc, beat, code, il);
            e.last = !full && (beat == len - 1);
            e.tag  = tag;
            exp_q.push_back(e);
            held = e.col;
            adv = stall ? (c % 3 != 1) : 1'b1;
            tn  = term && (c == maxc - 1);
            advance = adv;
            terminate = tn;
            if (chg_mode && c == 0) begin
                mode_load = 1'b1; mode_bl = 3'd0; mode_ilv = ~il;
            end
            @(posedge clk); #1;
            mode_load = 1'b0;
            terminate = 1'b0;
            if (tn) active = 1'b0;
            else if (adv) begin
                if (!full && beat == len - 1) active = 1'b0;
                else beat++;
            end
        end
        advance = 1'b0;
        @(negedge clk);
        check(busy === 1'b0, {tag, " burst end busy"}, int'(busy), 0);
        check(col === held, {tag, " held col"}, int'(col), int'(held));
        check(exp_q.size() == 0, {tag, " beats left"}, exp_q.size(), 0);
    endtask

    task automatic burst(input logic [8:0] sc, input int maxc, input bit stall,
                         input bit term, input string tag);
        logic [8:0] h;
        start_pulse(sc);
        run_beats(sc, maxc, stall, term, 1'b0, tag, h);
    endtask

    initial begin
        logic [8:0] h;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(busy === 1'b0, "R9 reset busy", int'(busy), 0);
        check(last === 1'b0, "R9 reset last", int'(last), 0);
        check(col === 9'd0, "R9 reset col", int'(col), 0);
        rst_n = 1'b1;

        // reset mode: one beat, sequential
        burst(9'd37, 1, 1'b0, 1'b0, "R9/R10 reset mode single beat");

        set_mode(3'd1, 1'b0);
        burst(9'h0F3, 1, 1'b0, 1'b0, "R3 BL2 seq");
        set_mode(3'd2, 1'b0);
        burst(9'h1A6, 1, 1'b1, 1'b0, "R3/R11 BL4 seq stall");
        set_mode(3'd3, 1'b0);
        burst(9'h05D, 1, 1'b0, 1'b0, "R3/R5 BL8 seq");
        set_mode(3'd2, 1'b1);
        burst(9'h0A5, 1, 1'b0, 1'b0, "R4 BL4 ilv");
        set_mode(3'd3, 1'b1);
        burst(9'h1FB, 1, 1'b1, 1'b0, "R4/R11 BL8 ilv stall");
        set_mode(3'd7, 1'b0);
        burst(9'd509, 6, 1'b0, 1'b1, "R6 full page wrap");
        set_mode(3'd7, 1'b1);
        burst(9'h1FE, 7, 1'b1, 1'b1, "R6 full page ilv as seq");
        set_mode(3'd5, 1'b1);
        burst(9'h07C, 1, 1'b0, 1'b0, "R10 reserved code one beat");

        // terminate a fixed burst in the middle
        set_mode(3'd3, 1'b0);
        burst(9'h046, 3, 1'b0, 1'b1, "R7 terminate fixed");

        // restart during a burst, start beats terminate and advance
        start_pulse(9'd5);
        begin
            exp_t e;
            e.col = model_col(9'd5, 0, 3'd3, 1'b0); e.last = 1'b0; e.tag = "R2 before restart";
            exp_q.push_back(e);
            advance = 1'b1;
            @(posedge clk); #1;
            e.col = model_col(9'd5, 1, 3'd3, 1'b0);
            exp_q.push_back(e);
            start = 1'b1; start_col = 9'd200; terminate = 1'b1;
            @(posedge clk); #1;
            start = 1'b0; terminate = 1'b0; advance = 1'b0;
        end
        run_beats(9'd200, 1, 1'b0, 1'b0, 1'b0, "R2/R7 restart with start priority", h);

        // idle: advance and terminate have no effect
        @(posedge clk); #1;
        advance = 1'b1; terminate = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        advance = 1'b0; terminate = 1'b0;
        @(negedge clk);
        check(busy === 1'b0, "R8 idle busy", int'(busy), 0);
        check(col === h, "R8 idle col held", int'(col), int'(h));

        // mode load during a burst leaves it alone, next burst uses it
        set_mode(3'd2, 1'b0);
        start_pulse(9'h133);
        run_beats(9'h133, 1, 1'b0, 1'b0, 1'b1, "R1 mode load mid burst", h);
        tb_bl = 3'd0; tb_il = 1'b1;
        burst(9'h12A, 1, 1'b0, 1'b0, "R1 new mode takes effect");

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule